// File: doc/BRIEF.md
# Three-Wire Register Access Slave

This block gives a host controller read and write access to a bank of sixteen 16-bit control registers over a three-wire serial bus. The bus has three lines: an active-low select, a serial clock driven by the host, and one bidirectional data line. The block samples all three bus lines with its own faster system clock. Each line first passes through a synchroniser, and the block then finds the rising edges of the serial clock.

Each transfer opens with a 9-bit control word. The word holds a 4-bit chip identity with a direction bit placed inside it, followed by a 4-bit register index. A write then takes a 16-bit word into the chosen register. A read leaves half a bus cycle for the line to turn around, then drives the register contents out. Each bit is launched on a rising bus clock edge so that the host can sample it on the falling edge.

The whole bank is also presented in parallel as a flat vector, for use by the rest of the chip.

Top module: `tw_reg_slave`

## Requirements
- R1: A transfer opens on the first rising bus clock edge at which the select line is low. A transfer that has ended or been aborted leaves the block ready to open a fresh one.
- R2: The control word is 9 bits taken on consecutive rising edges. Its bit order is A7, A6, A5, direction, A4, A3, A2, A1, A0.
- R3: The block answers only when A7:A4 equals 0110b. A3:A0 then selects one of the registers 0 to 15.
- R4: A direction bit of 0 means write and a direction bit of 1 means read.
- R5: On a write, 16 data bits are taken MSB first on rising edges 10 through 25. The addressed register changes once, after the 16th bit, and no other register changes.
- R6: On a read, the register is driven MSB first, one bit per rising edge from edge 10 through edge 25. Each bit is stable by the following falling edge. The line is released at rising edge 26.
- R7: When A7:A4 differs from 0110b, the output enable stays low and no register changes until the select line returns high.
- R8: The output enable is low during the control word and at all times outside the data phase of a matching read. It drops within 3 system clocks of the select line going high.
- R9: A write whose select line returns high before the 16th data bit changes no register.
- R10: After reset, every register reads 0000h and the output enable is low.
- R11: Bus clock edges while the select line is high have no effect on the registers or on the data line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Serial clock from the host |
| bus_sel_n | input | 1 | Active-low transfer select |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Data bit driven during a read |
| sdio_oe | output | 1 | Pad output enable for sdio_out |
| regs_flat | output | 256 | Register bank; register i occupies bits 16*i+15 down to 16*i |

## Verification
The assertions assume that the bus lines change slowly compared with the system clock. Every bus clock phase and every select change must last for several system clocks, so that each bus edge yields exactly one rising-edge pulse after the synchronisers. The assertions also assume that the select and data lines are stable around each rising bus clock edge. The stimulus holds every bus clock phase for eight system clocks, changes data and select only while the bus clock is low, and separates transfers with idle time.

// File: rtl/tw_pkg.sv
// Package: shared types and constants of the three-wire register slave.
package tw_pkg;
    // Frame sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CTRL  = 3'd1,
        ST_WDATA = 3'd2,
        ST_RDATA = 3'd3,
        ST_WAIT  = 3'd4
    } tw_state_e;
endpackage

// File: rtl/tw_bus_sync.sv
// Module: tw_bus_sync
// Brings the three asynchronous bus lines into the system clock domain through
// a chain of STAGES flops. It also produces a one-cycle pulse for each rising
// edge of the bus clock.
// Assumes every bus clock phase lasts several system clocks.
module tw_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_sel_n,
    input  logic sdio_in,
    output logic clk_rise,
    output logic sel_n_s,
    output logic sdio_s
);
    // Bit order inside each stage: {data, select, clock}.
    localparam logic [2:0] IDLE_VAL = 3'b010;

    logic [2:0] chain [STAGES];
    logic       clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first capture of the raw pads.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= IDLE_VAL;
                    else        chain[0] <= {sdio_in, bus_sel_n, bus_clk};
                end
            end else begin : g_next
                // Purpose: further resolution stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= IDLE_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Purpose: remember the last synchronised bus clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= chain[STAGES-1][0];
    end

    assign clk_rise = chain[STAGES-1][0] & ~clk_prev;
    assign sel_n_s  = chain[STAGES-1][1];
    assign sdio_s   = chain[STAGES-1][2];

    // A rise pulse never lasts two cycles.
    AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rise |=> !clk_rise) else $error("rise pulse too long"); // R1
endmodule

// File: rtl/tw_reg_bank.sv
// Module: tw_reg_bank
// Bank of 2**ADDR_W registers, each DATA_W bits wide. It has one synchronous
// write port and a combinational read port. The bank is also presented as a
// flat vector.
// Assumes wr_en is a single-cycle pulse.
module tw_reg_bank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [(2**ADDR_W)*DATA_W-1:0]     bank_flat
);
    localparam int NUM_REGS = 2**ADDR_W;

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    genvar i;
    generate
        for (i = 0; i < NUM_REGS; i++) begin : g_reg
            // Purpose: hold one register; load it when addressed by a write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[i] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(i)))
                    regs_q[i] <= wr_data;
            end
            assign bank_flat[i*DATA_W +: DATA_W] = regs_q[i];
        end
    endgenerate

    assign rd_data = regs_q[rd_addr];

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_flat)) else $error("bank changed without write"); // R5
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en) else $error("write pulse too long"); // R5
endmodule

// File: rtl/tw_frame_ctrl.sv
// Module: tw_frame_ctrl
// Frame sequencer. It assembles the 9-bit control word and checks the chip
// identity. It then either collects 16 write bits or shifts out 16 read bits.
// It drops the frame whenever the synchronised select line is high.
// Assumes its inputs come from tw_bus_sync.
module tw_frame_ctrl
    import tw_pkg::*;
#(
    parameter int          DATA_W  = 16,
    parameter int          ADDR_W  = 4,
    parameter int          CHIP_W  = 4,
    parameter logic [3:0]  CHIP_ID = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_rise,
    input  logic              sel_n_s,
    input  logic              sdio_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdio_out,
    output logic              sdio_oe
);
    localparam int CTRL_W = CHIP_W + 1 + ADDR_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int RW_POS = ADDR_W + 1;

    tw_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CTRL_W-2:0]  ctrl_q;
    logic [DATA_W-1:0]  data_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               drive_q;
    logic               bit_q;

    logic [CTRL_W-1:0]  word;
    logic [CHIP_W-1:0]  chip_rx;
    logic               rw_rx;
    logic               last_ctrl;
    logic               last_wbit;

    // Decode of the control word, including the bit arriving now.
    assign word      = {ctrl_q, sdio_s};
    assign chip_rx   = {word[CTRL_W-1 -: CHIP_W-1], word[ADDR_W]};
    assign rw_rx     = word[RW_POS];
    assign rd_addr   = word[ADDR_W-1:0];
    assign last_ctrl = (state_q == ST_CTRL) && (cnt_q == CNT_W'(CTRL_W-1));
    assign last_wbit = (state_q == ST_WDATA) && (cnt_q == CNT_W'(DATA_W-1));

    assign wr_en   = clk_rise && !sel_n_s && last_wbit;
    assign wr_addr = addr_q;
    assign wr_data = {data_q[DATA_W-2:0], sdio_s};

    // Purpose: advance the frame on each rising bus edge; drop it when select is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ctrl_q  <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            drive_q <= 1'b0;
            bit_q   <= 1'b0;
        end else if (sel_n_s) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            drive_q <= 1'b0;
        end else if (clk_rise) begin
            unique case (state_q)
                ST_IDLE: begin
                    ctrl_q  <= {{(CTRL_W-2){1'b0}}, sdio_s};
                    cnt_q   <= CNT_W'(1);
                    state_q <= ST_CTRL;
                end
                ST_CTRL: begin
                    if (last_ctrl) begin
                        cnt_q  <= '0;
                        addr_q <= word[ADDR_W-1:0];
                        if (chip_rx != CHIP_ID) begin
                            state_q <= ST_WAIT;
                        end else if (rw_rx) begin
                            data_q  <= rd_data;
                            state_q <= ST_RDATA;
                        end else begin
                            state_q <= ST_WDATA;
                        end
                    end else begin
                        ctrl_q <= {ctrl_q[CTRL_W-3:0], sdio_s};
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end
                end
                ST_WDATA: begin
                    data_q <= {data_q[DATA_W-2:0], sdio_s};
                    cnt_q  <= cnt_q + CNT_W'(1);
                    if (last_wbit) state_q <= ST_WAIT;
                end
                ST_RDATA: begin
                    if (cnt_q < CNT_W'(DATA_W)) begin
                        drive_q <= 1'b1;
                        bit_q   <= data_q[DATA_W-1];
                        data_q  <= {data_q[DATA_W-2:0], 1'b0};
                        cnt_q   <= cnt_q + CNT_W'(1);
                    end else begin
                        drive_q <= 1'b0;
                        state_q <= ST_WAIT;
                    end
                end
                default: ;
            endcase
        end
    end

    assign sdio_out = bit_q;
    assign sdio_oe  = drive_q & ~sel_n_s;

    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (state_q == ST_RDATA)) else $error("drive outside read"); // R8
    AST_WDATA_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WDATA) |-> (cnt_q < CNT_W'(DATA_W))) else $error("write count overrun"); // R5
    AST_SEL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (state_q == ST_IDLE && !drive_q)) else $error("select high did not abort"); // R9
    AST_WR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (state_q == ST_WAIT)) else $error("write not at frame end"); // R5
    AST_CTRL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTRL) |-> !drive_q) else $error("drive during control word"); // R8
endmodule

// File: rtl/tw_reg_slave.sv
// Module: tw_reg_slave (top)
// Three-wire register access slave: a bus synchroniser, a frame sequencer and
// a register bank.
// Assumes the system clock is several times faster than the bus clock.
module tw_reg_slave #(
    parameter int         DATA_W      = 16,
    parameter int         ADDR_W      = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] CHIP_ID     = 4'b0110
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_clk,
    input  logic                           bus_sel_n,
    input  logic                           sdio_in,
    output logic                           sdio_out,
    output logic                           sdio_oe,
    output logic [(2**ADDR_W)*DATA_W-1:0]  regs_flat
);
    logic              clk_rise;
    logic              sel_n_s;
    logic              sdio_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    tw_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_sel_n(bus_sel_n),
        .sdio_in(sdio_in), .clk_rise(clk_rise), .sel_n_s(sel_n_s), .sdio_s(sdio_s)
    );

    tw_frame_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHIP_W(4), .CHIP_ID(CHIP_ID)) u_frame (
        .clk(clk), .rst_n(rst_n), .clk_rise(clk_rise), .sel_n_s(sel_n_s),
        .sdio_s(sdio_s), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
    );

    tw_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .bank_flat(regs_flat)
    );

    AST_WR_SEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bus_sel_n || !sel_n_s) else $error("write while deselected"); // R9
endmodule

// File: tb/sim_tw_reg_slave.sv
// Bench for tw_reg_slave: a vector table walked by one loop, then directed cases.
module sim_tw_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HB         = 8;   // system clocks per bus clock phase

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_clk = 1'b0;
    logic         bus_sel_n = 1'b1;
    logic         sdio_in = 1'b0;
    logic         sdio_out;
    logic         sdio_oe;
    logic [255:0] regs_flat;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_reg_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_sel_n(bus_sel_n),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .regs_flat(regs_flat)
    );

    // Vector: {rw, chip[3:0], addr[3:0], data[15:0]}
    localparam int NV = 13;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'b0110, 4'd3,  16'hA5C3},
        {1'b0, 4'b0110, 4'd0,  16'hFFFF},
        {1'b0, 4'b0110, 4'd15, 16'h8001},
        {1'b1, 4'b0110, 4'd3,  16'h0000},
        {1'b1, 4'b0110, 4'd15, 16'h0000},
        {1'b1, 4'b0110, 4'd0,  16'h0000},
        {1'b0, 4'b0111, 4'd3,  16'h1111},
        {1'b0, 4'b1110, 4'd4,  16'h2222},
        {1'b1, 4'b0110, 4'd3,  16'h0000},
        {1'b1, 4'b0010, 4'd0,  16'h0000},
        {1'b0, 4'b0110, 4'd7,  16'h1234},
        {1'b1, 4'b0110, 4'd7,  16'h0000},
        {1'b1, 4'b0110, 4'd5,  16'h0000}
    };

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] model_flat();
        logic [255:0] v;
        for (int i = 0; i < 16; i++) v[i*16 +: 16] = model[i];
        return v;
    endfunction

    // One bus cycle: set data while low, raise clock, sample just before fall.
    task automatic bus_cycle(input logic d, output logic oe_s, output logic bit_s);
        sdio_in = d;
        wait_clks(HB);
        bus_clk = 1'b1;
        wait_clks(HB - 1);
        oe_s  = sdio_oe;
        bit_s = sdio_out;
        wait_clks(1);
        bus_clk = 1'b0;
    endtask

    // Frame with n_low rising edges under select low, then select high and one edge.
    task automatic frame(input logic rw, input logic [3:0] chip, input logic [3:0] addr,
                         input logic [15:0] wdata, input int n_low,
                         output logic [15:0] rdata, output int oe_ctrl,
                         output int oe_data, output int oe_end);
        logic [8:0] word;
        logic oe_s, bit_s, d;
        word = {chip[3:1], rw, chip[0], addr};
        rdata = '0; oe_ctrl = 0; oe_data = 0; oe_end = 0;
        bus_sel_n = 1'b0;
        for (int e = 0; e < n_low; e++) begin
            if (e < 9)       d = word[8-e];
            else if (!rw)    d = wdata[15-(e-9)];
            else             d = 1'b0;
            bus_cycle(d, oe_s, bit_s);
            if (e < 9) begin
                if (oe_s) oe_ctrl++;
            end else if (e < 25) begin
                if (oe_s) oe_data++;
                rdata[15-(e-9)] = bit_s;
            end
        end
        bus_sel_n = 1'b1;
        wait_clks(HB);
        bus_cycle(1'b0, oe_s, bit_s);
        if (oe_s) oe_end++;
        wait_clks(HB);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        int oc, od, oend;
        logic oe_s, bit_s;
        logic [24:0] v;
        logic match;
        for (int i = 0; i < 16; i++) model[i] = '0;

        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(4);
        // R10: reset state
        check(regs_flat == '0, "R10 bank after reset", regs_flat, '0);
        check(sdio_oe == 1'b0, "R10 oe after reset", 256'(sdio_oe), '0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            match = (v[23:20] == 4'b0110);
            frame(v[24], v[23:20], v[19:16], v[15:0], 25, rd, oc, od, oend);
            if (match && !v[24]) model[v[19:16]] = v[15:0];
            check(regs_flat == model_flat(), "R5 R7 bank after frame", regs_flat, model_flat());
            if (match && v[24]) begin
                check(rd == model[v[19:16]], "R6 read data", 256'(rd), 256'(model[v[19:16]]));
                check(od == 16 && oc == 0, "R8 oe only in data phase", 256'(od), 256'(16));
                check(oend == 0, "R6 released at edge 26", 256'(oend), '0);
            end else begin
                check(oc + od + oend == 0, "R7 R4 no drive", 256'(oc + od + oend), '0);
            end
        end

        // R9: write aborted after 5 data bits
        frame(1'b0, 4'b0110, 4'd9, 16'hBEEF, 14, rd, oc, od, oend);
        check(regs_flat == model_flat(), "R9 aborted write", regs_flat, model_flat());
        // R9: aborted one bit before the end
        frame(1'b0, 4'b0110, 4'd3, 16'h0F0F, 24, rd, oc, od, oend);
        check(regs_flat[3*16 +: 16] == model[3], "R9 abort at bit 15", 256'(regs_flat[3*16 +: 16]), 256'(model[3]));

        // R8: read aborted mid data; oe must drop within 3 clocks
        bus_sel_n = 1'b0;
        for (int e = 0; e < 13; e++) begin
            logic [8:0] w;
            w = {3'b011, 1'b1, 1'b0, 4'd0};
            bus_cycle(e < 9 ? w[8-e] : 1'b0, oe_s, bit_s);
        end
        check(oe_s == 1'b1, "R8 oe during read data", 256'(oe_s), 256'(1));
        bus_sel_n = 1'b1;
        wait_clks(3);
        check(sdio_oe == 1'b0, "R8 oe drops on select high", 256'(sdio_oe), '0);
        wait_clks(HB * 2);

        // R1: fresh transfer after abort
        frame(1'b1, 4'b0110, 4'd15, 16'h0, 25, rd, oc, od, oend);
        check(rd == model[15], "R1 read after abort", 256'(rd), 256'(model[15]));

        // R11: bus clock running with select high, write-like pattern
        bus_sel_n = 1'b1;
        oc = 0;
        for (int e = 0; e < 25; e++) begin
            logic [24:0] pat;
            pat = {9'b011001010, 16'hDEAD};
            bus_cycle(pat[24-e], oe_s, bit_s);
            if (oe_s) oc++;
        end
        check(oc == 0, "R11 no drive deselected", 256'(oc), '0);
        check(regs_flat == model_flat(), "R11 bank untouched", regs_flat, model_flat());

        // R3: address boundary 15 vs 0 after writes
        frame(1'b0, 4'b0110, 4'd15, 16'h7E57, 25, rd, oc, od, oend);
        model[15] = 16'h7E57;
        frame(1'b1, 4'b0110, 4'd15, 16'h0, 25, rd, oc, od, oend);
        check(rd == 16'h7E57, "R3 register 15", 256'(rd), 256'(16'h7E57));

        // R10: reset in mid-run clears the bank
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(2);
        check(regs_flat == '0, "R10 bank after second reset", regs_flat, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule